// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block sits beside a two-wire serial controller and decides whether the first byte after a START condition addresses this device. It watches SCL and SDA, which arrive already synchronized to the system clock. A START condition (SDA falling while SCL is high) opens an address phase. During that phase the block shifts in eight bits, one on each rising SCL edge. It then compares the upper seven bits against an own-address register that the CPU programs. When the low bit of that register is set, it also accepts the all-zero general-call byte.

A hit produces a one-cycle strobe, either `own_hit_o` or `gc_hit_o`. It also raises the level output `addressed_o` and latches the direction bit on `rw_o`. Both stay up until a STOP, a new START, a disable or master mode ends the transaction. The controller that instantiates the block generates the acknowledge and moves the data bytes.

The control is a four-state machine:
- `ST_IDLE` waits for a START.
- `ST_COLLECT` shifts in the address byte.
- `ST_ADDRESSED` holds a hit.
- `ST_IGNORED` waits out a transaction meant for another device.

Its transitions are:
- START: any state goes to `ST_COLLECT`.
- STOP: any state goes to `ST_IDLE`.
- Disable or master mode: any state is forced to `ST_IDLE`.
- Byte match: `ST_COLLECT` goes to `ST_ADDRESSED`.
- Byte mismatch: `ST_COLLECT` goes to `ST_IGNORED`.

Top module: `i2c_addr_recognizer`

## Requirements
- R1: A START condition (SDA goes 1 to 0 while SCL stays 1) begins address collection. Bits are taken from SDA on each rising SCL edge, most significant first, and eight bits make the address byte.
- R2: Let the collected byte be B and the register be A. If B[7:1] equals A[7:1], and B[7:1] is not zero, `own_hit_o` pulses high for exactly one clock, in the cycle after the clock edge that samples the eighth rising SCL edge. `addressed_o` rises in that same cycle.
- R3: Suppose A[0] = 1. Then B = 00H pulses `gc_hit_o` for one clock and raises `addressed_o`. Suppose A[0] = 0. Then B = 00H produces no strobe and leaves `addressed_o` low, even when A[7:1] is zero. Any B other than 00H never produces `gc_hit_o`.
- R4: `rw_o` equals B[0] (1 = read, 0 = write) while `addressed_o` is high. At all other times `rw_o` is 0.
- R5: After a non-matching byte, and after a hit, further SCL activity produces no strobe until a new START. This holds even when a later byte equals the own address.
- R6: A repeated START, including one in the middle of a byte, discards the bits collected so far and restarts collection at the first bit.
- R7: A STOP condition (SDA goes 0 to 1 while SCL stays 1) returns the block to idle. `addressed_o` and `rw_o` are low in the following cycle.
- R8: While `master_mode_i` is high, the own-address register is disregarded. No strobe fires, and `addressed_o` is low from the next cycle on.
- R9: While `enable_i` is low, bus activity is ignored and all match outputs are low from the next cycle on. The bit count restarts, so bits received before the disable never combine with later bits.
- R10: SDA transitions while SCL is low are neither START nor STOP, and they do not disturb address collection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Recognizer enable |
| master_mode_i | input | 1 | Controller is acting as bus master; suppresses matching |
| own_addr_i | input | 8 | CPU address register: [7:1] own address, [0] general-call enable |
| scl_i | input | 1 | Synchronized SCL sample |
| sda_i | input | 1 | Synchronized SDA sample |
| own_hit_o | output | 1 | One-cycle strobe: own address matched |
| gc_hit_o | output | 1 | One-cycle strobe: general call accepted |
| addressed_o | output | 1 | Device is addressed in the current transaction |
| rw_o | output | 1 | Captured direction bit (1 = read) while addressed |

## Verification
Suppose the bit counter or the machine state goes wrong. The result shows up at the ports no later than the end of the first address byte. The strobe fires one rising edge early or late, or it does not fire at all, and the bench sees this through its strobe counters within one clock of the eighth SCL rise. A state that fails to leave `ST_ADDRESSED` or `ST_IGNORED` shows up in two ways: `addressed_o` is still high one cycle after a STOP, or a later byte fails to match after a START. The directed scenarios inject repeated STARTs in the middle of a byte, disables during collection and SDA glitches while SCL is low, so that a stale count would shift the byte and break the compare.

// File: rtl/i2c_arec_pkg.sv
package i2c_arec_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_COLLECT   = 2'd1,
        ST_ADDRESSED = 2'd2,
        ST_IGNORED   = 2'd3
    } arec_state_e;

endpackage

// File: rtl/bus_cond_detect.sv
module bus_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic start_o,
    output logic stop_o
);

    logic scl_q;
    logic sda_q;

    // Previous samples track the bus even while disabled, so enabling
    // mid-transaction cannot create a false START or STOP.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        scl_rise_o = enable_i && scl_i && !scl_q;
        start_o    = enable_i && scl_i && scl_q && sda_q && !sda_i;
        stop_o     = enable_i && scl_i && scl_q && !sda_q && sda_i;
    end

endmodule

// File: rtl/addr_shifter.sv
module addr_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              shift_i,
    input  logic              bit_i,
    output logic              full_o,
    output logic [BYTE_W-1:0] byte_o
);

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BYTE_W - 1);

    logic [BYTE_W-2:0] shreg_q;
    logic [CNT_W-1:0]  cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            cnt_q   <= '0;
        end else if (clr_i) begin
            shreg_q <= '0;
            cnt_q   <= '0;
        end else if (shift_i) begin
            shreg_q <= {shreg_q[BYTE_W-3:0], bit_i};
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    // The final bit bypasses the register so the decision lands on the
    // same clock edge as the eighth SCL rise.
    always_comb begin
        full_o = shift_i && (cnt_q == LAST_IDX);
        byte_o = {shreg_q, bit_i};
    end

endmodule

// File: rtl/addr_compare.sv
module addr_compare #(
    parameter int ADDR_W = 7
) (
    input  logic [ADDR_W:0] byte_i,
    input  logic [ADDR_W:0] own_reg_i,
    output logic            own_hit_o,
    output logic            gc_hit_o
);

    logic addr_zero;

    always_comb begin
        addr_zero = (byte_i[ADDR_W:1] == '0);
        own_hit_o = !addr_zero && (byte_i[ADDR_W:1] == own_reg_i[ADDR_W:1]);
        gc_hit_o  = own_reg_i[0] && (byte_i == '0);
    end

endmodule

// File: rtl/i2c_addr_recognizer.sv
module i2c_addr_recognizer
    import i2c_arec_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable_i,
    input  logic            master_mode_i,
    input  logic [ADDR_W:0] own_addr_i,
    input  logic            scl_i,
    input  logic            sda_i,
    output logic            own_hit_o,
    output logic            gc_hit_o,
    output logic            addressed_o,
    output logic            rw_o
);

    localparam int BYTE_W = ADDR_W + 1;

    arec_state_e       state_q, state_d;
    logic              scl_rise, start_ev, stop_ev;
    logic              byte_full;
    logic [BYTE_W-1:0] rx_byte;
    logic              cmp_own, cmp_gc;
    logic              halt;
    logic              own_d, gc_d, rw_d, rw_q;
    logic              own_q, gc_q;
    logic              shift_en, shift_clr;

    bus_cond_detect u_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (enable_i),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .start_o    (start_ev),
        .stop_o     (stop_ev)
    );

    always_comb begin
        halt      = !enable_i || master_mode_i;
        shift_en  = scl_rise && (state_q == ST_COLLECT);
        shift_clr = halt || start_ev || (state_q != ST_COLLECT);
    end

    addr_shifter #(.BYTE_W(BYTE_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (shift_clr),
        .shift_i (shift_en),
        .bit_i   (sda_i),
        .full_o  (byte_full),
        .byte_o  (rx_byte)
    );

    addr_compare #(.ADDR_W(ADDR_W)) u_cmp (
        .byte_i    (rx_byte),
        .own_reg_i (own_addr_i),
        .own_hit_o (cmp_own),
        .gc_hit_o  (cmp_gc)
    );

    // Next-state and next-output decode
    always_comb begin
        state_d = state_q;
        own_d   = 1'b0;
        gc_d    = 1'b0;
        rw_d    = rw_q;
        if (halt || stop_ev) begin
            state_d = ST_IDLE;
            rw_d    = 1'b0;
        end else if (start_ev) begin
            state_d = ST_COLLECT;
            rw_d    = 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                end
                ST_COLLECT: begin
                    if (byte_full) begin
                        if (cmp_own || cmp_gc) begin
                            state_d = ST_ADDRESSED;
                            own_d   = cmp_own;
                            gc_d    = cmp_gc;
                            rw_d    = rx_byte[0];
                        end else begin
                            state_d = ST_IGNORED;
                            rw_d    = 1'b0;
                        end
                    end
                end
                ST_ADDRESSED: begin
                    state_d = ST_ADDRESSED;
                end
                ST_IGNORED: begin
                    state_d = ST_IGNORED;
                end
                default: begin
                    state_d = ST_IDLE;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            own_q <= 1'b0;
            gc_q  <= 1'b0;
            rw_q  <= 1'b0;
        end else begin
            own_q <= own_d;
            gc_q  <= gc_d;
            rw_q  <= rw_d;
        end
    end

    always_comb begin
        own_hit_o   = own_q;
        gc_hit_o    = gc_q;
        rw_o        = rw_q;
        addressed_o = (state_q == ST_ADDRESSED);
    end

endmodule

// File: rtl/i2c_arec_checker.sv
module i2c_arec_checker #(
    parameter int ADDR_W = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic            enable_i,
    input logic            master_mode_i,
    input logic [ADDR_W:0] own_addr_i,
    input logic            scl_i,
    input logic            sda_i,
    input logic            own_hit_o,
    input logic            gc_hit_o,
    input logic            addressed_o,
    input logic            rw_o
);

    assert_own_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        own_hit_o |=> !own_hit_o);

    assert_hit_raises_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (own_hit_o || gc_hit_o) |-> addressed_o);

    assert_strobes_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(own_hit_o && gc_hit_o));

    assert_gc_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        gc_hit_o |-> own_addr_i[0]);

    assert_rw_low_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !addressed_o |-> !rw_o);

    assert_stop_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && scl_i && $past(scl_i) && sda_i && !$past(sda_i)) |=> !addressed_o);

    assert_master_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        master_mode_i |=> (!addressed_o && !own_hit_o && !gc_hit_o));

    assert_disable_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (!addressed_o && !own_hit_o && !gc_hit_o && !rw_o));

endmodule

bind i2c_addr_recognizer i2c_arec_checker #(.ADDR_W(ADDR_W)) u_arec_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable_i      (enable_i),
    .master_mode_i (master_mode_i),
    .own_addr_i    (own_addr_i),
    .scl_i         (scl_i),
    .sda_i         (sda_i),
    .own_hit_o     (own_hit_o),
    .gc_hit_o      (gc_hit_o),
    .addressed_o   (addressed_o),
    .rw_o          (rw_o)
);

// File: tb/tb_i2c_addr_recognizer.sv
module tb_i2c_addr_recognizer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable_i = 1'b0;
    logic       master_mode_i = 1'b0;
    logic [7:0] own_addr_i = 8'h00;
    logic       scl_i = 1'b1;
    logic       sda_i = 1'b1;
    logic       own_hit_o, gc_hit_o, addressed_o, rw_o;

    int tests = 0;
    int fails = 0;
    int own_cnt = 0;
    int gc_cnt = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    i2c_addr_recognizer dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable_i      (enable_i),
        .master_mode_i (master_mode_i),
        .own_addr_i    (own_addr_i),
        .scl_i         (scl_i),
        .sda_i         (sda_i),
        .own_hit_o     (own_hit_o),
        .gc_hit_o      (gc_hit_o),
        .addressed_o   (addressed_o),
        .rw_o          (rw_o)
    );

    // Strobe monitors sample between edges
    always @(negedge clk) begin
        if (own_hit_o) own_cnt++;
        if (gc_hit_o)  gc_cnt++;
    end

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send_start;
        sda_i = 1'b1; scl_i = 1'b1; wait_n(2);
        sda_i = 1'b0; wait_n(2);
        scl_i = 1'b0; wait_n(2);
    endtask

    task automatic send_stop;
        scl_i = 1'b0; sda_i = 1'b0; wait_n(2);
        scl_i = 1'b1; wait_n(2);
        sda_i = 1'b1; wait_n(2);
    endtask

    task automatic send_bit(input logic b);
        scl_i = 1'b0; sda_i = b; wait_n(2);
        scl_i = 1'b1; wait_n(2);
        scl_i = 1'b0; wait_n(1);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
    endtask

    task automatic t_reset;
        chk("R4 reset rw", rw_o, 0);
        chk("R2 reset addressed", addressed_o, 0);
        chk("R2 reset strobes", own_hit_o | gc_hit_o, 0);
    endtask

    task automatic t_own_write;
        int o0 = own_cnt;
        own_addr_i = 8'hA4;
        send_start;
        send_byte(8'hA4);
        chk("R2 own strobe count", own_cnt - o0, 1);
        chk("R1 R2 addressed", addressed_o, 1);
        chk("R4 rw write", rw_o, 0);
        send_byte(8'hA4);
        chk("R5 no strobe on data byte", own_cnt - o0, 1);
        send_stop;
        chk("R7 stop clears addressed", addressed_o, 0);
    endtask

    task automatic t_own_read;
        own_addr_i = 8'hA4;
        send_start;
        send_byte(8'hA5);
        chk("R4 rw read", rw_o, 1);
        send_stop;
        chk("R7 stop clears rw", rw_o, 0);
    endtask

    task automatic t_mismatch;
        int o0 = own_cnt;
        own_addr_i = 8'hA4;
        send_start;
        send_byte(8'h50);
        chk("R5 mismatch no strobe", own_cnt - o0, 0);
        chk("R5 mismatch not addressed", addressed_o, 0);
        send_byte(8'hA4);
        chk("R5 ignored until start", own_cnt - o0, 0);
        send_stop;
    endtask

    task automatic t_gc;
        int g0 = gc_cnt;
        int o0 = own_cnt;
        own_addr_i = 8'hA5;
        send_start;
        send_byte(8'h00);
        chk("R3 gc strobe", gc_cnt - g0, 1);
        chk("R3 gc no own", own_cnt - o0, 0);
        chk("R3 gc addressed", addressed_o, 1);
        send_stop;
        send_start;
        send_byte(8'h01);
        chk("R3 01H not gc", gc_cnt - g0, 1);
        chk("R3 01H not addressed", addressed_o, 0);
        send_stop;
        own_addr_i = 8'h00;
        send_start;
        send_byte(8'h00);
        chk("R3 gc disabled zero reg", gc_cnt - g0 + own_cnt - o0, 1);
        chk("R3 gc disabled addressed", addressed_o, 0);
        send_stop;
    endtask

    task automatic t_restart;
        int o0 = own_cnt;
        own_addr_i = 8'h3C;
        send_start;
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        send_start;
        send_byte(8'h3C);
        chk("R6 restart mid-byte", own_cnt - o0, 1);
        send_start;
        send_byte(8'h3E);
        chk("R6 restart drops addressed", addressed_o, 0);
        send_stop;
    endtask

    task automatic t_master;
        int o0 = own_cnt;
        own_addr_i = 8'hA4;
        master_mode_i = 1'b1;
        send_start;
        send_byte(8'hA4);
        chk("R8 master no strobe", own_cnt - o0, 0);
        chk("R8 master not addressed", addressed_o, 0);
        send_stop;
        master_mode_i = 1'b0;
    endtask

    task automatic t_disable;
        int o0 = own_cnt;
        own_addr_i = 8'hA4;
        enable_i = 1'b0;
        send_start;
        send_byte(8'hA4);
        chk("R9 disabled no strobe", own_cnt - o0, 0);
        send_stop;
        enable_i = 1'b1;
        send_start;
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        enable_i = 1'b0; wait_n(3);
        enable_i = 1'b1; wait_n(1);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
        chk("R9 count restarted", own_cnt - o0, 0);
        send_start;
        send_byte(8'hA4);
        enable_i = 1'b0; wait_n(2);
        chk("R9 disable clears addressed", addressed_o, 0);
        enable_i = 1'b1;
        send_stop;
    endtask

    task automatic t_glitch;
        int o0 = own_cnt;
        logic [7:0] b = 8'hA4;
        own_addr_i = 8'hA4;
        send_start;
        for (int i = 7; i >= 0; i--) begin
            scl_i = 1'b0;
            sda_i = ~b[i]; wait_n(1);
            sda_i = b[i];  wait_n(1);
            sda_i = ~b[i]; wait_n(1);
            send_bit(b[i]);
        end
        chk("R10 low-SCL toggles harmless", own_cnt - o0, 1);
        chk("R10 addressed", addressed_o, 1);
        send_stop;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        t_reset;
        enable_i = 1'b1;
        wait_n(2);
        t_own_write;
        t_own_read;
        t_mismatch;
        t_gc;
        t_restart;
        t_master;
        t_disable;
        t_glitch;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule